// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Controller

This block sits between a synchronous host and an external asynchronous static RAM of 524,288 bytes (19 address lines, 8 shared data lines). The host presents one single-byte read or write at a time with a request/ready handshake. The controller then generates the active-low chip-select, output-enable and write-enable strobes, holds the address and write data steady, and drives the shared data lines only inside a safe window. When an operation completes, it raises a one-cycle `done`. For a read, the captured byte appears on `rd_data` at the same time.

Each minimum interval the memory demands is converted into a whole number of clock cycles, rounded up, from two parameters: the clock period in picoseconds and a speed grade (0 for the 100 ns part, 1 for the 120 ns part). The read strobe length covers cycle time, address access, select access and output-enable access. The write-enable low window covers the write pulse, address-to-end, select-to-end and data-setup minimums. A recovery tail stretches each write to the full write cycle. A turnaround counter keeps the controller's data drivers off until the memory has had its maximum release time after a read.

Top module: `sram_async_ctl`

## Requirements
- R1: While and directly after reset, `sram_cs_n`, `sram_oe_n` and `sram_we_n` are 1, `sram_dq_oe` is 0, `ready` is 1 and `done` is 0.
- R2: A read holds `sram_cs_n` and `sram_oe_n` low and `sram_we_n` high for exactly RD_CYC consecutive cycles, with a stable address. RD_CYC is ceil(max(cycle, address access, select access, output-enable access) / clock period), which is 10 at the defaults (100 ns at a 10 ns clock).
- R3: At the clock edge that ends a read strobe, the byte on `sram_dq_in` is captured into `rd_data`, and `done` is 1 for exactly one cycle. Every write completion also gives one `done` pulse. Completions come back in request order.
- R4: A write holds `sram_cs_n` and `sram_we_n` low together for exactly W_CYC cycles, with `sram_oe_n` high throughout. W_CYC is ceil(max(write pulse, address-to-end, select-to-end, data setup) / clock period), which is 8 at the defaults (80 ns). The byte present on the data lines when the strobes rise is the byte stored.
- R5: `sram_dq_oe` is 1 only while `sram_we_n` is 0, and it falls at the same edge at which `sram_we_n` rises. The controller never drives while the memory is driving a read.
- R6: Two successive write strobe starts are at least WC_CYC = ceil(write cycle / clock period) cycles apart, which is 10 at the defaults.
- R7: `sram_dq_oe` rises no earlier than TA_CYC = ceil(output release time / clock period) cycles after `sram_oe_n` last rose, which is 3 at the defaults (30 ns).
- R8: `ready` is 0 whenever any strobe is active. A request is accepted only in a cycle where both `req` and `ready` are 1.
- R9: While `sram_cs_n` is 1, both `sram_oe_n` and `sram_we_n` are 1. `sram_oe_n` and `sram_we_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write byte |
| ready | output | 1 | Controller can take a request |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Captured read byte, valid with `done` |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_addr | output | 19 | Memory address |
| sram_dq_out | output | 8 | Data toward the memory |
| sram_dq_in | input | 8 | Data from the memory |
| sram_dq_oe | output | 1 | Drive enable for `sram_dq_out` |

## Verification
The assertions assume that the host applies `req` and its fields in a way that is only sampled when `ready` is 1. They also assume that the memory side respects the strobes and drives data only during an output-enabled read. The bench's memory model follows these rules. Its driver raises requests at falling edges and holds them until an accepting rising edge. The model returns a filler byte until the full read access count has passed, so a capture taken too early shows up as a data mismatch. The model also flags any overlap between its own drive and `sram_dq_oe`.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WWAIT,
    ST_WLOW,
    ST_WREC
  } sramc_st_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // nanoseconds to clock cycles, rounded up, never below one
  function automatic int ns2cyc(input int ns, input int clk_ps);
    int c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/sramc_timer.sv
module sramc_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/sramc_seq.sv
module sramc_seq
  import sramc_pkg::*;
#(
  parameter int AW     = 19,
  parameter int DW     = 8,
  parameter int CW     = 5,
  parameter int RD_CYC = 10,
  parameter int W_CYC  = 8,
  parameter int R_CYC  = 2,
  parameter int TA_CYC = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          ready,
  output logic          done,
  output logic [DW-1:0] rd_data,
  input  logic          tmr_zero,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  input  logic          ta_zero,
  output logic          ta_load,
  output logic [CW-1:0] ta_val,
  output logic          cs_n,
  output logic          oe_n,
  output logic          we_n,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] dq_out,
  input  logic [DW-1:0] dq_in,
  output logic          dq_oe
);
  sramc_st_e st;

  logic take;
  logic wr_go;
  logic rd_end;
  logic wr_end;

  assign ready  = (st == ST_IDLE);
  assign take   = ready && req;
  assign wr_go  = (take && req_write && ta_zero) || (st == ST_WWAIT && ta_zero);
  assign rd_end = (st == ST_RD) && tmr_zero;
  assign wr_end = (st == ST_WLOW) && tmr_zero;

  // interval timer load values per phase
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (take && !req_write) begin
      tmr_load = 1'b1;
      tmr_val  = CW'(RD_CYC - 1);
    end else if (wr_go) begin
      tmr_load = 1'b1;
      tmr_val  = CW'(W_CYC - 1);
    end else if (wr_end && R_CYC > 0) begin
      tmr_load = 1'b1;
      tmr_val  = CW'((R_CYC > 0) ? R_CYC - 1 : 0);
    end
  end

  assign ta_load = rd_end;
  assign ta_val  = CW'(TA_CYC - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cs_n    <= 1'b1;
      oe_n    <= 1'b1;
      we_n    <= 1'b1;
      dq_oe   <= 1'b0;
      addr    <= '0;
      dq_out  <= '0;
      done    <= 1'b0;
      rd_data <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req) begin
            addr <= req_addr;
            if (req_write) begin
              dq_out <= req_wdata;
              if (ta_zero) begin
                cs_n  <= 1'b0;
                we_n  <= 1'b0;
                dq_oe <= 1'b1;
                st    <= ST_WLOW;
              end else begin
                st <= ST_WWAIT;
              end
            end else begin
              cs_n <= 1'b0;
              oe_n <= 1'b0;
              st   <= ST_RD;
            end
          end
        end
        ST_RD: begin
          if (tmr_zero) begin
            rd_data <= dq_in;
            cs_n    <= 1'b1;
            oe_n    <= 1'b1;
            done    <= 1'b1;
            st      <= ST_IDLE;
          end
        end
        ST_WWAIT: begin
          if (ta_zero) begin
            cs_n  <= 1'b0;
            we_n  <= 1'b0;
            dq_oe <= 1'b1;
            st    <= ST_WLOW;
          end
        end
        ST_WLOW: begin
          if (tmr_zero) begin
            cs_n  <= 1'b1;
            we_n  <= 1'b1;
            dq_oe <= 1'b0;
            done  <= 1'b1;
            st    <= (R_CYC > 0) ? ST_WREC : ST_IDLE;
          end
        end
        ST_WREC: begin
          if (tmr_zero) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R9: write enable only inside a select window
  p_we_in_cs_r9: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> !cs_n);
  // R4: no read enable during a write
  p_no_oe_in_write_r4: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> oe_n);
  // R2: address does not move inside a strobe window
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && $past(!cs_n)) |-> $stable(addr));
  // R3: completion is a single-cycle pulse
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R5: drivers on only while write enable is low
  p_drive_in_we_r5: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> !we_n);
  // R8: no acceptance while a strobe is active
  p_busy_r8: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> !ready);
endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
  import sramc_pkg::*;
#(
  parameter int CLK_PS      = 10000,
  parameter int SPEED_GRADE = 0,
  parameter int AW          = 19,
  parameter int DW          = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          ready,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic          sram_cs_n,
  output logic          sram_oe_n,
  output logic          sram_we_n,
  output logic [AW-1:0] sram_addr,
  output logic [DW-1:0] sram_dq_out,
  input  logic [DW-1:0] sram_dq_in,
  output logic          sram_dq_oe
);
  // minimum intervals in ns per grade
  localparam bit SLOW   = (SPEED_GRADE != 0);
  localparam int T_RC   = SLOW ? 120 : 100;
  localparam int T_AA   = SLOW ? 120 : 100;
  localparam int T_CO   = SLOW ? 120 : 100;
  localparam int T_OE   = SLOW ? 60  : 50;
  localparam int T_WC   = SLOW ? 120 : 100;
  localparam int T_WP   = SLOW ? 80  : 70;
  localparam int T_AW   = SLOW ? 100 : 80;
  localparam int T_CW   = SLOW ? 100 : 80;
  localparam int T_DW   = SLOW ? 50  : 40;
  localparam int T_HZ   = SLOW ? 35  : 30;

  localparam int RD_CYC = ns2cyc(imax(imax(T_RC, T_AA), imax(T_CO, T_OE)), CLK_PS);
  localparam int W_CYC  = ns2cyc(imax(imax(T_WP, T_AW), imax(T_CW, T_DW)), CLK_PS);
  localparam int WC_CYC = ns2cyc(T_WC, CLK_PS);
  localparam int R_CYC  = (WC_CYC > W_CYC) ? WC_CYC - W_CYC : 0;
  localparam int TA_CYC = ns2cyc(T_HZ, CLK_PS);
  localparam int CW     = $clog2(imax(imax(RD_CYC, W_CYC), imax(WC_CYC, TA_CYC)) + 1) + 1;

  logic          tmr_load, tmr_zero, ta_load, ta_zero;
  logic [CW-1:0] tmr_val, ta_val;

  sramc_timer #(.CW(CW)) u_phase_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  sramc_timer #(.CW(CW)) u_turn_tmr (
    .clk(clk), .rst(rst), .load(ta_load), .load_val(ta_val), .zero(ta_zero)
  );

  sramc_seq #(
    .AW(AW), .DW(DW), .CW(CW),
    .RD_CYC(RD_CYC), .W_CYC(W_CYC), .R_CYC(R_CYC), .TA_CYC(TA_CYC)
  ) u_seq (
    .clk(clk), .rst(rst),
    .req(req), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .ready(ready), .done(done), .rd_data(rd_data),
    .tmr_zero(tmr_zero), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .ta_zero(ta_zero), .ta_load(ta_load), .ta_val(ta_val),
    .cs_n(sram_cs_n), .oe_n(sram_oe_n), .we_n(sram_we_n),
    .addr(sram_addr), .dq_out(sram_dq_out), .dq_in(sram_dq_in), .dq_oe(sram_dq_oe)
  );

  // cycles since output enable was last low, saturating
  logic [CW-1:0] since_oe;
  always_ff @(posedge clk) begin
    if (rst)                        since_oe <= CW'(TA_CYC);
    else if (!sram_oe_n)            since_oe <= '0;
    else if (since_oe < CW'(TA_CYC)) since_oe <= since_oe + 1'b1;
  end

  // R7: bus turnaround after a read before driving
  p_turnaround_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_dq_oe) |-> (since_oe >= CW'(TA_CYC)));
  // R9: deselected means both enables idle
  p_desel_idle_r9: assert property (@(posedge clk) disable iff (rst)
    sram_cs_n |-> (sram_oe_n && sram_we_n));
endmodule

// File: tb/sram_async_ctl_bench.sv
module sram_async_ctl_bench;
  localparam int RD_N = 10;
  localparam int WR_N = 8;
  localparam int WC_N = 10;
  localparam int TA_N = 3;
  localparam logic [7:0] FILL = 8'h5A;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        ready, done;
  logic [7:0]  rd_data;
  logic        cs_n, oe_n, we_n, dq_oe;
  logic [18:0] s_addr;
  logic [7:0]  dq_out, dq_in;

  always #5 clk = ~clk;

  sram_async_ctl u_sram_async_ctl (
    .clk(clk), .rst(rst), .req(req), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .ready(ready), .done(done), .rd_data(rd_data),
    .sram_cs_n(cs_n), .sram_oe_n(oe_n), .sram_we_n(we_n), .sram_addr(s_addr),
    .sram_dq_out(dq_out), .sram_dq_in(dq_in), .sram_dq_oe(dq_oe)
  );

  int errors = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
    end
  endtask

  // memory model
  bit [7:0] mem [int];
  int rd_cnt = 0, wr_cnt = 0;
  logic [7:0] rd_val = '0;
  int wa; logic [7:0] wd;
  logic model_drv;
  assign model_drv = !cs_n && !oe_n && we_n;
  assign dq_in = (model_drv && rd_cnt >= RD_N) ? rd_val : FILL;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic prev_oe_n = 1'b1, prev_dq_oe = 1'b0, prev_wr = 1'b0, prev_done = 1'b0;
  int last_oe_rise = -100, last_wr_start = -100;

  typedef struct { bit rd; logic [7:0] d; } exp_t;
  exp_t q[$];
  bit [7:0] shadow [int];

  always @(negedge clk) begin
    if (!rst) begin
      if (model_drv) begin
        rd_cnt++;
        rd_val = mem.exists(int'(s_addr)) ? mem[int'(s_addr)] : 8'h00;
        chk(ready == 1'b0, "R8 ready during read", ready, 0);
      end else if (rd_cnt != 0) begin
        chk(rd_cnt == RD_N, "R2 read strobe length", rd_cnt, RD_N);
        rd_cnt = 0;
      end
      if (!cs_n && !we_n) begin
        if (!prev_wr) begin
          chk(cyc - last_wr_start >= WC_N, "R6 write spacing", cyc - last_wr_start, WC_N);
          last_wr_start = cyc;
          chk(oe_n == 1'b1, "R4 oe high in write", oe_n, 1);
        end
        chk(dq_oe == 1'b1, "R5 drive while we low", dq_oe, 1);
        wr_cnt++; wa = int'(s_addr); wd = dq_out;
      end else if (wr_cnt != 0) begin
        chk(wr_cnt == WR_N, "R4 write strobe length", wr_cnt, WR_N);
        chk(dq_oe == 1'b0, "R5 release with we", dq_oe, 0);
        mem[wa] = wd;
        wr_cnt = 0;
      end
      if (model_drv && dq_oe) chk(0, "R5 bus contention", 1, 0);
      if (cs_n && !(oe_n && we_n)) chk(0, "R9 enables while deselected", {oe_n, we_n}, 3);
      if (!oe_n && !we_n) chk(0, "R9 oe and we both low", 0, 1);
      if (!prev_oe_n && oe_n) last_oe_rise = cyc;
      if (!prev_dq_oe && dq_oe)
        chk(cyc - last_oe_rise >= TA_N, "R7 turnaround", cyc - last_oe_rise, TA_N);
      if (done) begin
        if (prev_done) chk(0, "R3 done longer than one cycle", 2, 1);
        if (q.size() == 0) chk(0, "R3 unexpected done", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          if (e.rd) chk(rd_data == e.d, "R3 read data", rd_data, e.d);
        end
      end
      prev_oe_n = oe_n; prev_dq_oe = dq_oe; prev_wr = !cs_n && !we_n; prev_done = done;
    end
  end

  task automatic issue(input bit wr, input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    req = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!ready) @(negedge clk);
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic do_write(input logic [18:0] a, input logic [7:0] d);
    exp_t e;
    shadow[int'(a)] = d;
    e.rd = 1'b0; e.d = d;
    q.push_back(e);
    issue(1'b1, a, d);
  endtask

  task automatic do_read(input logic [18:0] a);
    exp_t e;
    e.rd = 1'b1;
    e.d = shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
    q.push_back(e);
    issue(1'b0, a, 8'h00);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state while reset is held
    chk(cs_n && oe_n && we_n, "R1 strobes idle in reset", {cs_n, oe_n, we_n}, 7);
    chk(dq_oe == 1'b0 && done == 1'b0, "R1 no drive no done", {dq_oe, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(ready == 1'b1, "R1 ready after reset", ready, 1);
    chk(cs_n && oe_n && we_n && !dq_oe, "R1 idle after reset", {cs_n, oe_n, we_n, dq_oe}, 14);

    do_write(19'h00000, 8'h00);
    do_write(19'h7FFFF, 8'hFF);
    do_write(19'h12345, 8'hA5);
    do_read(19'h7FFFF);
    do_read(19'h00000);
    do_read(19'h12345);
    do_read(19'h00777);            // never written
    do_write(19'h00010, 8'h3C);    // directly after a read: turnaround
    do_read(19'h00010);
    do_write(19'h00010, 8'hC3);    // overwrite
    do_write(19'h00011, 8'h81);
    do_read(19'h00010);
    do_read(19'h00011);
    for (int i = 0; i < 6; i++) do_write(19'(i * 4099), 8'(i * 37 + 1));
    for (int i = 0; i < 6; i++) do_read(19'(i * 4099));

    while (q.size() != 0 || !ready) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(q.size() == 0, "R3 all completions seen", q.size(), 0);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end
endmodule